// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is the control core of one DMA channel. Software programs a 32-bit control word through a plain write/read register port. From that word the block takes the channel enable, a software start for memory-to-memory copies, an abort request, the source and destination data widths and the largest source burst. A three-state sequencer uses these settings to issue burst commands to an external data mover. The states are idle, active and closing. Each burst command carries a beat count and a beat size. The mover reports the end of each burst with a completion strobe. That strobe has a flag that marks the last burst of the buffer.

There are two ways to run the channel. With the software start bit clear, the channel serves a peripheral. It issues one burst for each request and closes once the peripheral signals that it is done. With the start bit set, the channel copies memory to memory. It issues bursts back to back, and the peripheral request and done lines are ignored. Every return to idle clears the enable bit, so software must write the enable bit again before the channel can run another transfer.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the control word reads 0, `chan_state` is idle (code 0), and `burst_start`, `idle_pulse` and `cfg_err` are all low.
- R2: A register write stores the whole 32-bit word, and the stored word reads back on `reg_rd_data` from the next cycle on. `chan_state` shows idle as 0, active as 1 and closing as 2.
- R3: Enable is bit 31. If the stored word has enable set and valid widths, the channel moves from idle to active one cycle later. With start (bit 29) clear, the channel is in peripheral mode. In that mode `burst_start` is high only while `periph_req` is high, the channel is active and no burst is in flight.
- R4: Start is bit 29. If start and enable are set together, the channel runs memory-to-memory. It issues a burst in every active cycle that has no burst in flight, and it ignores `periph_req` and `periph_done`. Start reads back 0 once the channel has left idle.
- R5: A burst is in flight from its `burst_start` cycle until `mover_done`. No new `burst_start` is issued during that time. A `mover_done` with no burst in flight has no effect.
- R6: Abort is bit 30. If abort is set while a burst is in flight, the channel stays active until `mover_done` arrives and then goes to closing. If abort is set with no burst in flight, the channel goes to closing in the next cycle and issues no further burst.
- R7: `mover_done` together with `mover_last` ends the transfer in both modes. In peripheral mode, a `periph_done` seen during the transfer closes the channel when the current burst completes. If no burst is in flight, that `periph_done` closes the channel at once.
- R8: Closing lasts exactly one cycle and then the channel returns to idle. `idle_pulse` is high for one cycle, in the first idle cycle. On entry to idle the enable and abort bits are cleared.
- R9: Once the channel is back in idle it stays there until enable is written to 1 again. A register write made in the closing cycle takes priority over the automatic clearing.
- R10: Bits 28:27 hold the source width and bits 26:25 hold the destination width. The codes are 00 for 8 bits, 01 for 16 bits and 10 for 32 bits. Code 11 in either field raises `cfg_err` and keeps the channel in idle.
- R11: Bits 24:23 select the burst. The codes are 00 for one source unit, 01 for 4 bytes, 10 for 16 bytes and 11 for 32 bytes. `burst_beats` is the burst size in bytes divided by the source width in bytes, with a minimum of 1. `burst_size` repeats the source width code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 32 | Control word write value |
| reg_rd_data | output | 32 | Current control word |
| periph_req | input | 1 | Peripheral has a full burst ready |
| periph_done | input | 1 | Peripheral has finished the transfer |
| mover_done | input | 1 | Data mover finished the current burst |
| mover_last | input | 1 | Completed burst was the buffer's last |
| burst_start | output | 1 | One-cycle burst command |
| burst_beats | output | 6 | Beats in the commanded burst |
| burst_size | output | 2 | Beat size code (source width) |
| chan_state | output | 2 | Channel state: 0 idle, 1 active, 2 closing |
| idle_pulse | output | 1 | One-cycle marker of a return to idle |
| cfg_err | output | 1 | Reserved width code in the control word |

## Verification
Software can write the control word in the same cycle that the sequencer clears the enable and abort bits on the way back to idle. The same holds for the cycle that clears the start bit on launch. The bench waits until its model reports the closing state and then writes enable in exactly that cycle. It expects the written word to survive intact and the channel to restart after one idle cycle. A second overlap appears when `periph_done` or abort arrives in the same cycle as `mover_done`. The cycle-level model judges every such case on every clock against the state, the readback and the burst outputs.

// File: rtl/dma_seq_pkg.sv
// Shared definitions for the DMA channel sequencer: control-word field
// positions, reserved code and the channel state encoding.
package dma_seq_pkg;
    localparam int CTRL_W    = 32;
    localparam int EN_BIT    = 31;
    localparam int ABORT_BIT = 30;
    localparam int GO_BIT    = 29;
    localparam int SRCW_LO   = 27;
    localparam int DSTW_LO   = 25;
    localparam int BURST_LO  = 23;
    localparam logic [1:0] WIDTH_RSVD = 2'b11;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_ACTIVE  = 2'd1,
        CH_CLOSING = 2'd2
    } ch_state_e;
endpackage

// File: rtl/dma_ctl_regs.sv
// Control word storage. Holds the 32-bit word written by software.
// Assumes: a software write takes priority over both hardware clears
// (start bit on launch, enable and abort on idle entry).
module dma_ctl_regs
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              clr_go,
    input  logic              clr_idle,
    output logic [CTRL_W-1:0] ctrl_q
);
    // Store the word; apply the self-clears only when no write is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end else begin
            if (clr_go) begin
                ctrl_q[GO_BIT] <= 1'b0;
            end
            if (clr_idle) begin
                ctrl_q[EN_BIT]    <= 1'b0;
                ctrl_q[ABORT_BIT] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_beat_calc.sv
// Burst beat calculator. Turns the source width code and the burst code
// into a beat count, computed as a power of two from log2 sizes.
// Assumes: burst sizes are powers of two, up to 2**MAX_BURST_LOG2 bytes.
module dma_beat_calc #(
    parameter int MAX_BURST_LOG2 = 5,
    parameter int BEAT_W         = MAX_BURST_LOG2 + 1
) (
    input  logic [1:0]        src_w,
    input  logic [1:0]        burst_code,
    output logic [BEAT_W-1:0] beats
);
    localparam int LG_W = $clog2(MAX_BURST_LOG2 + 1) + 1;

    logic [LG_W-1:0] lg_bytes;
    logic [LG_W-1:0] lg_src;
    logic [LG_W-1:0] shift;

    // Map the burst code to log2 of its byte count (code 0 means one unit).
    always_comb begin
        lg_src = LG_W'(src_w);
        case (burst_code)
            2'd1:    lg_bytes = LG_W'(2);
            2'd2:    lg_bytes = LG_W'(4);
            2'd3:    lg_bytes = LG_W'(MAX_BURST_LOG2);
            default: lg_bytes = lg_src;
        endcase
    end

    // Divide by the source width as a log2 subtraction, with a floor of one beat.
    always_comb begin
        shift = (lg_bytes > lg_src) ? (lg_bytes - lg_src) : '0;
        beats = BEAT_W'(1) << shift;
    end
endmodule

// File: rtl/dma_chan_fsm.sv
// Channel sequencer: idle -> active -> closing -> idle. In active it issues
// bursts (on request in peripheral mode, back to back in memory mode),
// tracks one burst in flight and decides when to close.
// Assumes: the mover completes each burst with one mover_done strobe.
module dma_chan_fsm
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      abort,
    input  logic      go_bit,
    input  logic      cfg_err,
    input  logic      periph_req,
    input  logic      periph_done,
    input  logic      mover_done,
    input  logic      mover_last,
    output ch_state_e state_q,
    output logic      launch,
    output logic      closing,
    output logic      idle_pulse,
    output logic      burst_start
);
    ch_state_e state_d;
    logic      mem_mode_q;
    logic      busy_q;
    logic      seen_done_q;
    logic      periph_end;

    assign periph_end  = !mem_mode_q && (seen_done_q || periph_done);
    assign launch      = (state_q == CH_IDLE) && en && !cfg_err;
    assign closing     = (state_q == CH_CLOSING);
    assign burst_start = (state_q == CH_ACTIVE) && !busy_q && !abort &&
                         !periph_end && (mem_mode_q || periph_req);

    // Next-state decision for the channel.
    always_comb begin
        state_d = state_q;
        case (state_q)
            CH_IDLE: begin
                if (launch) begin
                    state_d = CH_ACTIVE;
                end
            end
            CH_ACTIVE: begin
                if (busy_q) begin
                    if (mover_done && (abort || mover_last || periph_end)) begin
                        state_d = CH_CLOSING;
                    end
                end else if (abort || periph_end) begin
                    state_d = CH_CLOSING;
                end
            end
            CH_CLOSING: state_d = CH_IDLE;
            default:    state_d = CH_IDLE;
        endcase
    end

    // State, mode, burst-in-flight and peripheral-done tracking registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CH_IDLE;
            mem_mode_q  <= 1'b0;
            busy_q      <= 1'b0;
            seen_done_q <= 1'b0;
            idle_pulse  <= 1'b0;
        end else begin
            state_q    <= state_d;
            idle_pulse <= closing;
            if (launch) begin
                mem_mode_q  <= go_bit;
                busy_q      <= 1'b0;
                seen_done_q <= 1'b0;
            end else begin
                if (burst_start) begin
                    busy_q <= 1'b1;
                end else if (busy_q && mover_done) begin
                    busy_q <= 1'b0;
                end
                if ((state_q == CH_ACTIVE) && !mem_mode_q && periph_done) begin
                    seen_done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dma_chan_seq.sv
// Top of one DMA channel's control unit: control word, beat calculation
// and channel sequencer. Data movement is left to an external mover.
// Assumes: one register write port, and no burst is started outside active.
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int MAX_BURST_LOG2 = 5,
    parameter int BEAT_W         = MAX_BURST_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wr_data,
    output logic [31:0]       reg_rd_data,
    input  logic              periph_req,
    input  logic              periph_done,
    input  logic              mover_done,
    input  logic              mover_last,
    output logic              burst_start,
    output logic [BEAT_W-1:0] burst_beats,
    output logic [1:0]        burst_size,
    output logic [1:0]        chan_state,
    output logic              idle_pulse,
    output logic              cfg_err
);
    logic [CTRL_W-1:0] ctrl;
    logic [1:0]        src_w;
    logic [1:0]        dst_w;
    logic [1:0]        burst_code;
    logic              launch;
    logic              closing;
    ch_state_e         state;

    assign src_w       = ctrl[SRCW_LO +: 2];
    assign dst_w       = ctrl[DSTW_LO +: 2];
    assign burst_code  = ctrl[BURST_LO +: 2];
    assign cfg_err     = (src_w == WIDTH_RSVD) || (dst_w == WIDTH_RSVD);
    assign reg_rd_data = ctrl;
    assign burst_size  = src_w;
    assign chan_state  = state;

    dma_ctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .clr_go   (launch),
        .clr_idle (closing),
        .ctrl_q   (ctrl)
    );

    dma_beat_calc #(
        .MAX_BURST_LOG2 (MAX_BURST_LOG2),
        .BEAT_W         (BEAT_W)
    ) u_beats (
        .src_w      (src_w),
        .burst_code (burst_code),
        .beats      (burst_beats)
    );

    dma_chan_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl[EN_BIT]),
        .abort       (ctrl[ABORT_BIT]),
        .go_bit      (ctrl[GO_BIT]),
        .cfg_err     (cfg_err),
        .periph_req  (periph_req),
        .periph_done (periph_done),
        .mover_done  (mover_done),
        .mover_last  (mover_last),
        .state_q     (state),
        .launch      (launch),
        .closing     (closing),
        .idle_pulse  (idle_pulse),
        .burst_start (burst_start)
    );
endmodule

// File: rtl/dma_chan_seq_chk.sv
// Property checker for dma_chan_seq, attached by bind. Observes ports only.
module dma_chan_seq_chk #(
    parameter int BEAT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [31:0]       reg_rd_data,
    input logic              burst_start,
    input logic [BEAT_W-1:0] burst_beats,
    input logic [1:0]        chan_state,
    input logic              idle_pulse,
    input logic              cfg_err
);
    assert_leave_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_state == 2'd0 && reg_rd_data[31] && !cfg_err) |=> chan_state == 2'd1);

    assert_burst_only_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> chan_state == 2'd1);

    assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !burst_start);

    assert_closing_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chan_state == 2'd2 |=> (chan_state == 2'd0 && idle_pulse));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pulse |=> !idle_pulse);

    assert_enable_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_pulse && !$past(reg_wr_en)) |-> (!reg_rd_data[31] && !reg_rd_data[30]));

    assert_err_holds_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_state == 2'd0 && cfg_err) |=> chan_state == 2'd0);

    assert_beats_pow2_R11: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> $countones(burst_beats) == 1);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_data (reg_rd_data),
    .burst_start (burst_start),
    .burst_beats (burst_beats),
    .chan_state  (chan_state),
    .idle_pulse  (idle_pulse),
    .cfg_err     (cfg_err)
);

// File: tb/dma_chan_seq_test.sv
// Bench: a behavioural cycle model is compared with every output each cycle.
module dma_chan_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        periph_req = 1'b0;
    logic        periph_done = 1'b0;
    logic        mover_done = 1'b0;
    logic        mover_last = 1'b0;
    logic        burst_start;
    logic [5:0]  burst_beats;
    logic [1:0]  burst_size;
    logic [1:0]  chan_state;
    logic        idle_pulse;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [31:0] m_ctrl = '0;
    int          m_state = 0;
    bit          m_mem = 0;
    bit          m_busy = 0;
    bit          m_seen = 0;
    bit          m_pulse = 0;

    dma_chan_seq uut (
        .clk (clk), .rst_n (rst_n),
        .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
        .periph_req (periph_req), .periph_done (periph_done),
        .mover_done (mover_done), .mover_last (mover_last),
        .burst_start (burst_start), .burst_beats (burst_beats), .burst_size (burst_size),
        .chan_state (chan_state), .idle_pulse (idle_pulse), .cfg_err (cfg_err)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] mk(bit en, bit ab, bit go, int sw, int dw, int sb);
        logic [31:0] w;
        w = '0;
        w[31] = en; w[30] = ab; w[29] = go;
        w[28:27] = 2'(sw); w[26:25] = 2'(dw); w[24:23] = 2'(sb);
        return w;
    endfunction

    // One clock: drive, compare against model, advance model.
    task automatic step(bit wr, logic [31:0] wd, bit req, bit pd, bit md, bit ml, string tag);
        int  sw, dw, sb, bytes, e_beats;
        bit  en, ab, go, e_err, pend, e_bs, go_now, close;
        @(negedge clk);
        reg_wr_en = wr; reg_wr_data = wd; periph_req = req;
        periph_done = pd; mover_done = md; mover_last = ml;
        #1;
        sw = int'(m_ctrl[28:27]); dw = int'(m_ctrl[26:25]); sb = int'(m_ctrl[24:23]);
        en = m_ctrl[31]; ab = m_ctrl[30]; go = m_ctrl[29];
        e_err = (sw == 3) || (dw == 3);
        case (sb)
            1: bytes = 4;
            2: bytes = 16;
            3: bytes = 32;
            default: bytes = 1 << sw;
        endcase
        e_beats = bytes / (1 << sw);
        if (e_beats == 0) e_beats = 1;
        pend = (m_state == 1) && !m_mem && (m_seen || pd);
        e_bs = (m_state == 1) && !m_busy && !ab && !pend && (m_mem || req);
        checks++;
        if (chan_state !== 2'(m_state) || idle_pulse !== m_pulse || burst_start !== e_bs ||
            burst_beats !== 6'(e_beats) || burst_size !== 2'(sw) ||
            reg_rd_data !== m_ctrl || cfg_err !== e_err) begin
            errors++;
            $display("FAIL %s: state %0d/%0d pulse %0b/%0b start %0b/%0b beats %0d/%0d size %0d/%0d rd %h/%h err %0b/%0b",
                     tag, chan_state, m_state, idle_pulse, m_pulse, burst_start, e_bs,
                     burst_beats, e_beats, burst_size, sw, reg_rd_data, m_ctrl, cfg_err, e_err);
        end
        // advance model
        go_now = (m_state == 0) && en && !e_err;
        close = 0;
        m_pulse = (m_state == 2);
        if (m_state == 1) begin
            if (m_busy) begin
                if (md) begin
                    m_busy = 0;
                    if (ab || ml || pend) close = 1;
                end
            end else if (ab || pend) begin
                close = 1;
            end else if (e_bs) begin
                m_busy = 1;
            end
            if (!m_mem && pd) m_seen = 1;
        end
        if (wr) begin
            m_ctrl = wd;
        end else begin
            if (go_now) m_ctrl[29] = 1'b0;
            if (m_state == 2) begin m_ctrl[31] = 1'b0; m_ctrl[30] = 1'b0; end
        end
        if (go_now) begin
            m_mem = go; m_busy = 0; m_seen = 0; m_state = 1;
        end else if (m_state == 2) begin
            m_state = 0;
        end else if (close) begin
            m_state = 2;
        end
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle(2, "R1");
        // R10: reserved width codes hold idle
        step(1, mk(1,0,0,3,0,0), 0,0,0,0, "R10");
        idle(3, "R10");
        step(1, mk(1,0,0,0,3,0), 0,0,0,0, "R10");
        idle(3, "R10");
        // R2: whole-word readback
        step(1, mk(0,0,0,1,2,1) | 32'h0000_1234, 0,0,0,0, "R2");
        idle(2, "R2");
        // R3: peripheral mode, bursts only on request
        step(1, mk(1,0,0,2,2,3), 0,0,0,0, "R3");
        idle(3, "R3");
        step(0, '0, 0,0,1,0, "R5");        // stray mover_done ignored
        step(0, '0, 1,0,0,0, "R11");       // 8 beats
        for (int i = 0; i < 3; i++) step(0, '0, 1,0,0,0, "R5");
        step(0, '0, 0,0,1,0, "R5");
        step(0, '0, 1,0,0,0, "R3");
        step(0, '0, 0,1,0,0, "R7");        // peripheral done during burst
        idle(2, "R7");
        step(0, '0, 1,0,1,0, "R7");        // completion closes
        idle(3, "R8");
        // R9: stays idle without a new enable write
        idle(5, "R9");
        // R4: memory-to-memory ignores the peripheral lines
        step(1, mk(1,0,1,0,0,2), 0,0,0,0, "R4");
        for (int i = 0; i < 8; i++) step(0, '0, i % 2 == 1, 1, i == 3 || i == 6, 0, "R4");
        for (int i = 0; i < 4; i++) step(0, '0, 0,0,1,1, "R7");
        idle(3, "R8");
        // R6: abort with a burst in flight
        step(1, mk(1,0,1,1,1,1), 0,0,0,0, "R6");
        idle(3, "R6");
        step(1, mk(1,1,0,1,1,1), 0,0,0,0, "R6");
        idle(3, "R6");
        step(0, '0, 0,0,1,0, "R6");
        idle(3, "R6");
        // R6: abort with nothing in flight
        step(1, mk(1,0,0,0,0,0), 0,0,0,0, "R6");
        idle(2, "R6");
        step(1, mk(1,1,0,0,0,0), 0,0,0,0, "R6");
        idle(3, "R6");
        // R9: write in the closing cycle wins over the auto-clear
        step(1, mk(1,0,1,2,2,0), 0,0,0,0, "R9");
        idle(2, "R9");
        step(0, '0, 0,0,1,1, "R9");
        for (int i = 0; i < 4 && m_state != 2; i++) idle(1, "R9");
        step(1, mk(1,0,0,2,2,0), 0,0,0,0, "R9");
        idle(3, "R9");
        step(1, mk(1,1,0,2,2,0), 0,0,0,0, "R9");
        idle(3, "R9");
        // R11: beat counts for several width/burst pairs
        step(1, mk(0,0,0,2,0,0), 0,0,0,0, "R11");
        step(1, mk(0,0,0,0,0,3), 0,0,0,0, "R11");
        step(1, mk(0,0,0,1,0,2), 0,0,0,0, "R11");
        step(1, mk(0,0,0,1,0,0), 0,0,0,0, "R11");
        step(1, mk(0,0,0,2,1,1), 0,0,0,0, "R11");
        idle(2, "R11");
        finish_run();
    end
endmodule